// File: doc/BRIEF.md
# Tile Occlusion Culler

This block holds a coarse depth picture of the screen: one conservative maximum depth per 8x8-pixel tile of a 256x256 screen. Ahead of rasterization it takes a batch of triangles summarised as a screen-space rectangle plus the batch's nearest depth, and decides whether the whole batch is hidden. It walks the tiles under the rectangle, one per cycle, in row-major order.

The batch is culled only when its nearest depth lies strictly behind the stored maximum of every covered tile. The walk stops at the first tile where the batch could be seen. The batch then passes, and a second walk folds the batch's farthest depth into every covered tile that holds a value. A separate port lets rasterization raise a tile's maximum. A frame clear returns every tile to the far value, one tile per cycle, and blocks queries while it runs.

Top module: `occ_culler`

## Requirements
- R1: After reset `done_o` and `cull_o` are low, `qry_ready_o` is high, and every tile reads as far (all ones), so no query can be culled.
- R2: A pixel coordinate p maps to tile column/row p>>3. The rectangle is inclusive on both corners, and corners given in either order cover the same tiles.
- R3: A query is culled (`cull_o`=1) only when `qry_zmin_i` is strictly greater than the stored value of every covered tile. Equality passes.
- R4: With n covered tiles, a culled query raises `done_o` n cycles after the accepting edge. A query first seen at covered tile k (1-based, row-major) raises it k+n cycles after. `done_o` is a one-cycle pulse, and `cull_o` changes only when `done_o` is high.
- R5: When a query passes, every covered tile that holds a written value becomes max(value, `qry_zmax_i`). Tiles still at far stay far.
- R6: A tile update sets the tile to `upd_depth_i` if the tile is at its cleared state. Otherwise the tile becomes the maximum of its value and `upd_depth_i`.
- R7: An update to the tile the query reads in that same cycle is applied first, so the query sees the updated value.
- R8: After a `clr_i` pulse with the block idle, `qry_ready_o` stays low for exactly 1024 cycles. All tiles then read far. Updates offered during the clear are discarded.
- R9: A `clr_i` pulse during a query does not change that query's result. The clear starts after the query's `done_o`.
- R10: A query is accepted only on a cycle with `qry_valid_i` and `qry_ready_o` both high. `qry_ready_o` is low throughout a walk or clear, and a request offered then produces no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Frame clear request pulse |
| qry_valid_i | input | 1 | Batch query request |
| qry_ready_o | output | 1 | Query can be accepted this cycle |
| qry_x0_i | input | 8 | Rectangle corner A, pixel column |
| qry_y0_i | input | 8 | Rectangle corner A, pixel row |
| qry_x1_i | input | 8 | Rectangle corner B, pixel column |
| qry_y1_i | input | 8 | Rectangle corner B, pixel row |
| qry_zmin_i | input | 24 | Nearest depth of the batch |
| qry_zmax_i | input | 24 | Farthest depth of the batch |
| upd_valid_i | input | 1 | Tile update strobe |
| upd_tx_i | input | 5 | Tile column of update |
| upd_ty_i | input | 5 | Tile row of update |
| upd_depth_i | input | 24 | Update depth |
| done_o | output | 1 | Verdict strobe |
| cull_o | output | 1 | Verdict: 1 culled, 0 passed |

## Verification
A corrupted tile value shows up as a wrong verdict on the first later query that covers that tile. A corrupted stored value is also exposed by the pass-merge walk, which turns it into a false cull on the next query. A walker or FSM fault shows up as a `done_o` latency that differs from n or k+n. This catches a missing early stop, a missed restart or a lost step within one query. A clear that is too short or too long moves the `qry_ready_o` rise away from exactly 1024 cycles. A dropped forwarding path or a leaked update flips the verdict of the query issued right after it.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_MERGE = 2'd2,
    ST_CLEAR = 2'd3
  } occ_state_e;
endpackage

// File: rtl/occ_tile_store.sv
module occ_tile_store #(
  parameter int IDX_W   = 10,
  parameter int DEPTH_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic               rd_written_o,
  output logic [DEPTH_W-1:0] rd_depth_o,
  input  logic               clr_we_i,
  input  logic               mrg_we_i,
  input  logic [DEPTH_W-1:0] mrg_val_i,
  input  logic               upd_we_i,
  input  logic [IDX_W-1:0]   upd_idx_i,
  input  logic [DEPTH_W-1:0] upd_val_i
);
  localparam int NT = 1 << IDX_W;

  logic [NT-1:0]      written_q;
  logic [DEPTH_W-1:0] depth_q [NT];

  logic [DEPTH_W-1:0] upd_old;
  logic [DEPTH_W-1:0] upd_new;
  logic               upd_hit;

  assign upd_old = depth_q[upd_idx_i];
  always_comb begin
    upd_new = upd_val_i;
    if (written_q[upd_idx_i] && upd_old > upd_val_i) upd_new = upd_old;
  end

  // same-cycle update to the read tile is forwarded
  assign upd_hit      = upd_we_i && (upd_idx_i == rd_idx_i);
  assign rd_written_o = upd_hit ? 1'b1 : written_q[rd_idx_i];
  assign rd_depth_o   = upd_hit ? upd_new : depth_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      written_q <= '0;
    end else if (clr_we_i) begin
      written_q[rd_idx_i] <= 1'b0;
    end else if (upd_we_i) begin
      written_q[upd_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (clr_we_i) begin
      depth_q[rd_idx_i] <= '1;
    end else begin
      if (upd_we_i) depth_q[upd_idx_i] <= upd_new;
      // merge value already includes any forwarded update
      if (mrg_we_i) depth_q[rd_idx_i] <= mrg_val_i;
    end
  end
endmodule

// File: rtl/occ_rect_walker.sv
module occ_rect_walker #(
  parameter int TC_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  input  logic            restart_i,
  input  logic [TC_W-1:0] xl_i,
  input  logic [TC_W-1:0] xh_i,
  input  logic [TC_W-1:0] yl_i,
  input  logic [TC_W-1:0] yh_i,
  output logic [TC_W-1:0] cx_o,
  output logic [TC_W-1:0] cy_o,
  output logic            last_o
);
  logic [TC_W-1:0] xl_q, xh_q, yl_q, yh_q;
  logic [TC_W-1:0] cx_q, cy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xl_q <= '0;
      xh_q <= '0;
      yl_q <= '0;
      yh_q <= '0;
      cx_q <= '0;
      cy_q <= '0;
    end else if (load_i) begin
      xl_q <= xl_i;
      xh_q <= xh_i;
      yl_q <= yl_i;
      yh_q <= yh_i;
      cx_q <= xl_i;
      cy_q <= yl_i;
    end else if (restart_i) begin
      cx_q <= xl_q;
      cy_q <= yl_q;
    end else if (step_i) begin
      if (cx_q == xh_q) begin
        cx_q <= xl_q;
        cy_q <= cy_q + 1'b1;
      end else begin
        cx_q <= cx_q + 1'b1;
      end
    end
  end

  assign cx_o   = cx_q;
  assign cy_o   = cy_q;
  assign last_o = (cx_q == xh_q) && (cy_q == yh_q);
endmodule

// File: rtl/occ_ctrl.sv
module occ_ctrl
  import occ_pkg::*;
#(
  parameter int DEPTH_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               qry_valid_i,
  input  logic [DEPTH_W-1:0] qry_zmin_i,
  input  logic [DEPTH_W-1:0] qry_zmax_i,
  output logic               qry_ready_o,
  input  logic               rd_written_i,
  input  logic [DEPTH_W-1:0] rd_depth_i,
  input  logic               last_i,
  output logic               load_o,
  output logic               load_full_o,
  output logic               step_o,
  output logic               restart_o,
  output logic               clr_we_o,
  output logic               mrg_we_o,
  output logic [DEPTH_W-1:0] mrg_val_o,
  output logic               clearing_o,
  output logic               done_o,
  output logic               cull_o
);
  occ_state_e         st_q, st_d;
  logic               pend_q, pend_d;
  logic [DEPTH_W-1:0] zmin_q, zmax_q;
  logic               done_q, done_d;
  logic               cull_q, cull_d;
  logic [DEPTH_W-1:0] eff_depth;
  logic               hidden;

  assign eff_depth   = rd_written_i ? rd_depth_i : '1;
  assign hidden      = zmin_q > eff_depth;
  assign mrg_val_o   = (rd_depth_i > zmax_q) ? rd_depth_i : zmax_q;
  assign qry_ready_o = (st_q == ST_IDLE) && !pend_q && !clr_i;
  assign clearing_o  = (st_q == ST_CLEAR);

  always_comb begin
    st_d        = st_q;
    pend_d      = pend_q | (clr_i && (st_q != ST_IDLE));
    load_o      = 1'b0;
    load_full_o = 1'b0;
    step_o      = 1'b0;
    restart_o   = 1'b0;
    clr_we_o    = 1'b0;
    mrg_we_o    = 1'b0;
    done_d      = 1'b0;
    cull_d      = cull_q;
    unique case (st_q)
      ST_IDLE: begin
        if (clr_i || pend_q) begin
          st_d        = ST_CLEAR;
          load_o      = 1'b1;
          load_full_o = 1'b1;
          pend_d      = 1'b0;
        end else if (qry_valid_i) begin
          st_d   = ST_SCAN;
          load_o = 1'b1;
        end
      end
      ST_SCAN: begin
        if (!hidden) begin
          st_d      = ST_MERGE;
          restart_o = 1'b1;
        end else if (last_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          cull_d = 1'b1;
        end else begin
          step_o = 1'b1;
        end
      end
      ST_MERGE: begin
        mrg_we_o = rd_written_i;
        if (last_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          cull_d = 1'b0;
        end else begin
          step_o = 1'b1;
        end
      end
      ST_CLEAR: begin
        clr_we_o = 1'b1;
        if (last_i) st_d = ST_IDLE;
        else        step_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      zmin_q <= '0;
      zmax_q <= '0;
      done_q <= 1'b0;
      cull_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      done_q <= done_d;
      cull_q <= cull_d;
      if (st_q == ST_IDLE && qry_ready_o && qry_valid_i) begin
        zmin_q <= qry_zmin_i;
        zmax_q <= qry_zmax_i;
      end
    end
  end

  assign done_o = done_q;
  assign cull_o = cull_q;
endmodule

// File: rtl/occ_culler.sv
module occ_culler #(
  parameter int SCR_LOG2  = 8,
  parameter int TILE_LOG2 = 3,
  parameter int DEPTH_W   = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                qry_valid_i,
  output logic                qry_ready_o,
  input  logic [SCR_LOG2-1:0] qry_x0_i,
  input  logic [SCR_LOG2-1:0] qry_y0_i,
  input  logic [SCR_LOG2-1:0] qry_x1_i,
  input  logic [SCR_LOG2-1:0] qry_y1_i,
  input  logic [DEPTH_W-1:0]  qry_zmin_i,
  input  logic [DEPTH_W-1:0]  qry_zmax_i,
  input  logic                upd_valid_i,
  input  logic [SCR_LOG2-TILE_LOG2-1:0] upd_tx_i,
  input  logic [SCR_LOG2-TILE_LOG2-1:0] upd_ty_i,
  input  logic [DEPTH_W-1:0]  upd_depth_i,
  output logic                done_o,
  output logic                cull_o
);
  localparam int TC_W  = SCR_LOG2 - TILE_LOG2;
  localparam int IDX_W = 2 * TC_W;

  logic [TC_W-1:0] ax, bx, ay, by;
  logic [TC_W-1:0] rxl, rxh, ryl, ryh;
  logic [TC_W-1:0] wxl, wxh, wyl, wyh;
  logic [TC_W-1:0] cx, cy;
  logic            last, load, load_full, step, restart;
  logic            clr_we, mrg_we, clearing, upd_we;
  logic [DEPTH_W-1:0] mrg_val, rd_depth;
  logic            rd_written;

  assign ax = qry_x0_i[SCR_LOG2-1:TILE_LOG2];
  assign bx = qry_x1_i[SCR_LOG2-1:TILE_LOG2];
  assign ay = qry_y0_i[SCR_LOG2-1:TILE_LOG2];
  assign by = qry_y1_i[SCR_LOG2-1:TILE_LOG2];

  assign rxl = (ax < bx) ? ax : bx;
  assign rxh = (ax < bx) ? bx : ax;
  assign ryl = (ay < by) ? ay : by;
  assign ryh = (ay < by) ? by : ay;

  assign wxl = load_full ? '0 : rxl;
  assign wxh = load_full ? '1 : rxh;
  assign wyl = load_full ? '0 : ryl;
  assign wyh = load_full ? '1 : ryh;

  assign upd_we = upd_valid_i && !clearing;

  occ_rect_walker #(.TC_W(TC_W)) u_walk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .restart_i(restart),
    .xl_i     (wxl),
    .xh_i     (wxh),
    .yl_i     (wyl),
    .yh_i     (wyh),
    .cx_o     (cx),
    .cy_o     (cy),
    .last_o   (last)
  );

  occ_tile_store #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    ({cy, cx}),
    .rd_written_o(rd_written),
    .rd_depth_o  (rd_depth),
    .clr_we_i    (clr_we),
    .mrg_we_i    (mrg_we),
    .mrg_val_i   (mrg_val),
    .upd_we_i    (upd_we),
    .upd_idx_i   ({upd_ty_i, upd_tx_i}),
    .upd_val_i   (upd_depth_i)
  );

  occ_ctrl #(.DEPTH_W(DEPTH_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .qry_valid_i (qry_valid_i),
    .qry_zmin_i  (qry_zmin_i),
    .qry_zmax_i  (qry_zmax_i),
    .qry_ready_o (qry_ready_o),
    .rd_written_i(rd_written),
    .rd_depth_i  (rd_depth),
    .last_i      (last),
    .load_o      (load),
    .load_full_o (load_full),
    .step_o      (step),
    .restart_o   (restart),
    .clr_we_o    (clr_we),
    .mrg_we_o    (mrg_we),
    .mrg_val_o   (mrg_val),
    .clearing_o  (clearing),
    .done_o      (done_o),
    .cull_o      (cull_o)
  );
endmodule

// File: rtl/occ_culler_chk.sv
module occ_culler_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clr_i,
  input logic qry_ready_o,
  input logic done_o,
  input logic cull_o
);
  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_busy_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !$past(qry_ready_o));

  a_r8_clear_blocks_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !qry_ready_o);

  a_r4_cull_moves_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cull_o) |-> done_o);
endmodule

bind occ_culler occ_culler_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .qry_ready_o(qry_ready_o),
  .done_o     (done_o),
  .cull_o     (cull_o)
);

// File: tb/occ_culler_test.sv
`timescale 1ns/1ps
module occ_culler_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        qry_valid_i = 1'b0;
  logic        qry_ready_o;
  logic [7:0]  qry_x0_i = '0, qry_y0_i = '0, qry_x1_i = '0, qry_y1_i = '0;
  logic [23:0] qry_zmin_i = '0, qry_zmax_i = '0;
  logic        upd_valid_i = 1'b0;
  logic [4:0]  upd_tx_i = '0, upd_ty_i = '0;
  logic [23:0] upd_depth_i = '0;
  logic        done_o, cull_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  occ_culler uut (.*);

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic upd(input int tx, input int ty, input int d);
    @(negedge clk_i);
    upd_valid_i = 1'b1;
    upd_tx_i = 5'(tx);
    upd_ty_i = 5'(ty);
    upd_depth_i = 24'(d);
    @(negedge clk_i);
    upd_valid_i = 1'b0;
  endtask

  task automatic query(input int x0, input int y0, input int x1, input int y1,
                       input int zmin, input int zmax, output int cul, output int lat);
    int cnt;
    @(negedge clk_i);
    qry_x0_i = 8'(x0); qry_y0_i = 8'(y0);
    qry_x1_i = 8'(x1); qry_y1_i = 8'(y1);
    qry_zmin_i = 24'(zmin); qry_zmax_i = 24'(zmax);
    qry_valid_i = 1'b1;
    @(negedge clk_i);
    qry_valid_i = 1'b0;
    cnt = 1;
    while (!done_o && cnt < 4000) begin
      @(negedge clk_i);
      cnt++;
    end
    lat = cnt - 1;
    cul = int'(cull_o);
  endtask

  task automatic t_reset();
    int c, l;
    check("R1 done", int'(done_o), 0);
    check("R1 cull", int'(cull_o), 0);
    check("R1 ready", int'(qry_ready_o), 1);
    query(255, 255, 255, 255, 24'hFFFFFF, 0, c, l);
    check("R1 far tile passes", c, 0);
    check("R4 pass latency 1+1", l, 2);
  endtask

  task automatic t_single();
    int c, l;
    upd(2, 3, 1000);
    query(16, 24, 23, 31, 1001, 0, c, l);
    check("R3 hidden culls", c, 1);
    check("R4 cull latency 1", l, 1);
    query(16, 24, 23, 31, 1000, 0, c, l);
    check("R3 equal passes", c, 0);
    upd(2, 3, 500);
    query(16, 24, 23, 31, 1001, 0, c, l);
    check("R6 lower update keeps max", c, 1);
    upd(2, 3, 2000);
    query(16, 24, 23, 31, 1001, 0, c, l);
    check("R6 higher update raises", c, 0);
  endtask

  task automatic t_multi();
    int c, l;
    upd(4, 4, 100); upd(5, 4, 100); upd(4, 5, 100); upd(5, 5, 100);
    query(47, 47, 32, 32, 200, 0, c, l);
    check("R2 swapped corners cull", c, 1);
    check("R4 cull latency 4", l, 4);
    query(32, 32, 55, 47, 200, 0, c, l);
    check("R3 one visible tile passes", c, 0);
    check("R4 early stop latency 3+6", l, 9);
    query(40, 32, 40, 32, 200, 0, c, l);
    check("R2 pixel 40 in tile 5", c, 1);
    query(48, 32, 48, 32, 200, 0, c, l);
    check("R2 pixel 48 in tile 6", c, 0);
  endtask

  task automatic t_merge();
    int c, l;
    upd(10, 10, 100);
    query(80, 80, 95, 80, 50, 300, c, l);
    check("R5 merging query passes", c, 0);
    query(80, 80, 80, 80, 200, 0, c, l);
    check("R5 written tile raised to zmax", c, 0);
    query(80, 80, 80, 80, 301, 0, c, l);
    check("R5 raised tile bound is zmax", c, 1);
    query(88, 80, 88, 80, 24'hFFFFFE, 0, c, l);
    check("R5 far tile stays far", c, 0);
  endtask

  task automatic t_forward();
    int cnt;
    @(negedge clk_i);
    qry_x0_i = 8'd160; qry_y0_i = 8'd160; qry_x1_i = 8'd160; qry_y1_i = 8'd160;
    qry_zmin_i = 24'd500; qry_zmax_i = 24'd0;
    qry_valid_i = 1'b1;
    @(negedge clk_i);
    qry_valid_i = 1'b0;
    upd_valid_i = 1'b1; upd_tx_i = 5'd20; upd_ty_i = 5'd20; upd_depth_i = 24'd100;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    check("R7 done after one tile", int'(done_o), 1);
    check("R7 same-cycle update seen", int'(cull_o), 1);
  endtask

  task automatic t_clear();
    int c, l, low, dn;
    @(negedge clk_i);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    low = 1; dn = 0;
    while (!qry_ready_o && low < 3000) begin
      if (low == 10) begin
        qry_valid_i = 1'b1; qry_x0_i = 0; qry_y0_i = 0; qry_x1_i = 0; qry_y1_i = 0;
      end
      if (low == 11) qry_valid_i = 1'b0;
      if (low == 500) begin
        upd_valid_i = 1'b1; upd_tx_i = 5'd2; upd_ty_i = 5'd3; upd_depth_i = 24'd5;
      end
      if (low == 501) upd_valid_i = 1'b0;
      @(negedge clk_i);
      if (done_o) dn++;
      if (!qry_ready_o) low++;
    end
    check("R8 clear length", low, 1024);
    check("R10 no done during clear", dn, 0);
    query(16, 24, 16, 24, 6, 0, c, l);
    check("R8 update during clear dropped", c, 0);
    query(32, 32, 32, 32, 200, 0, c, l);
    check("R8 tiles far after clear", c, 0);
  endtask

  task automatic t_defer();
    int c, l, cnt;
    upd(0, 0, 10); upd(1, 0, 10); upd(2, 0, 10); upd(3, 0, 10);
    @(negedge clk_i);
    qry_x0_i = 0; qry_y0_i = 0; qry_x1_i = 31; qry_y1_i = 0;
    qry_zmin_i = 24'd20; qry_zmax_i = 24'd0;
    qry_valid_i = 1'b1;
    @(negedge clk_i);
    qry_valid_i = 1'b0;
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    cnt = 2;
    while (!done_o && cnt < 100) begin
      @(negedge clk_i);
      cnt++;
    end
    check("R9 query result kept", int'(cull_o), 1);
    check("R9 query latency unchanged", cnt - 1, 4);
    check("R9 clear follows", int'(qry_ready_o), 0);
    while (!qry_ready_o && cnt < 3000) begin
      @(negedge clk_i);
      cnt++;
    end
    query(0, 0, 0, 0, 20, 0, c, l);
    check("R9 deferred clear ran", c, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset_pre: begin
      check("R1 done in reset", int'(done_o), 0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_multi();
    t_merge();
    t_forward();
    t_clear();
    t_defer();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule